// File: doc/BRIEF.md
# Dual Alarm Interrupt Flag Logic

This block watches the running time of a clock/calendar and raises a flag whenever the time matches one of two programmable time-of-day alarms. The timekeeper supplies the current time as BCD bytes together with a strobe that lasts one cycle and is issued once per second. The block compares the time against each alarm only when that strobe is present. When an alarm matches, its flag sets and stays set until software clears it.

Each alarm has its own interrupt enable. A single shared active-low interrupt line goes low while any flag is set and that flag's enable is also on. Software programs the alarms, the enables and the flag clears through a simple write port. It reads the flags directly from the flag output.

Each alarm has four compare bytes: seconds, minutes, hours and day-or-date. Bit 7 of any compare byte marks that field as "don't care". Bit 6 of the day-or-date byte chooses whether that byte is compared against the weekday or against the day of the month.

Top module: `alarm_irq_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), both flags are 0 and irq_n is 1.
- R2: When tick is high and every unmasked field of alarm i equals the current time, flag i reads 1 on the cycle after that edge. Alarm i's bytes are at write addresses 4*i+0 (seconds), 4*i+1 (minutes), 4*i+2 (hours) and 4*i+3 (day/date). Seconds, minutes and hours compare bits 6:0 against the full current byte. Day/date compares bits 5:0.
- R3: A matching time presented while tick is low never sets a flag.
- R4: A compare byte with bit 7 set excludes that field from the match. A field with bit 7 clear must match exactly.
- R5: Bit 6 of the day/date byte selects the weekday input when 1 and the date input when 0.
- R6: The status register is at address 8+1 = 9, with flag i at bit i. Writing a 0 to bit i clears flag i. Writing a 1 leaves the flag unchanged, so a write can never set a flag.
- R7: If a match on tick and a clearing write to flag i happen in the same cycle, flag i is 1 afterwards.
- R8: The control register is at address 8, with enable i at bit i. irq_n is 0 exactly when some flag i is 1 and its enable i is 1.
- R9: The two alarms are independent: a match or a clear of one alarm leaves the other alarm's flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe issued once per time update |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours byte, BCD with mode bits |
| now_wday | input | 8 | Current weekday |
| now_date | input | 8 | Current day of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| alarm_flags | output | 2 | Sticky alarm flags, bit i is alarm i |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
The seconds field is swept over all 60 BCD values and the hours field over all 24 values, each against one fixed alarm. These sweeps show that exactly one time value sets the flag and that masked fields are ignored. A weekday sweep and a date sweep are run against the same day/date byte value, which separates the two settings of the select bit. All sixteen combinations of flag state and enable state are driven, so the interrupt output is checked against every combination of the two enables. Further sequences test the behaviour of the flags themselves:
- a matching time held while the strobe is low;
- a write of 1 to a flag;
- a clearing write that lands in the same cycle as a match.

// File: rtl/alarm_pkg.sv
// Package alarm_pkg: shared types and sizes for the alarm flag logic.
// Assumes BCD bytes supplied by an external timekeeper.
package alarm_pkg;
    localparam int FIELDS_PER_ALARM = 4;
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DD   = 3;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] date;
    } rtc_time_t;
endpackage

// File: rtl/alarm_match.sv
// Module alarm_match: combinational compare of one alarm against the time.
// Bit 7 of each byte masks the field. Bit 6 of the day/date byte picks
// weekday (1) or date (0). Assumes the inputs are stable while tick is high.
module alarm_match
    import alarm_pkg::*;
(
    input  rtc_time_t                             now,
    input  logic [FIELDS_PER_ALARM-1:0][7:0]      cfg,
    output logic                                  match
);
    logic sec_ok, min_ok, hour_ok, dd_ok;
    logic [7:0] dd_src;

    // Field comparisons with per-field mask and day/date selection.
    always_comb begin
        sec_ok  = cfg[F_SEC][7]  | ({1'b0, cfg[F_SEC][6:0]}  == now.sec);
        min_ok  = cfg[F_MIN][7]  | ({1'b0, cfg[F_MIN][6:0]}  == now.min);
        hour_ok = cfg[F_HOUR][7] | ({1'b0, cfg[F_HOUR][6:0]} == now.hour);
        dd_src  = cfg[F_DD][6] ? now.wday : now.date;
        dd_ok   = cfg[F_DD][7] | ({2'b00, cfg[F_DD][5:0]} == dd_src);
        match   = sec_ok & min_ok & hour_ok & dd_ok;
    end
endmodule

// File: rtl/alarm_flag.sv
// Module alarm_flag: one sticky alarm flag. A set event wins over a clear.
// Assumes set_evt is already qualified by the update strobe.
module alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag
);
    // Sticky flag register: set has priority, a clear needs an explicit event.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_evt) flag <= 1'b0;
    end

    assert_set_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    assert_rise_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(set_evt));
    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !flag);
    assert_fall_needs_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr_evt));
    assert_match_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && set_evt) |=> flag);
endmodule

// File: rtl/alarm_irq_unit.sv
// Module alarm_irq_unit: alarm compare registers, enables, sticky flags and
// a shared active-low interrupt. Assumes one tick per time update and that
// NUM_ALARMS is at most 8 (one status or enable bit per alarm).
module alarm_irq_unit
    import alarm_pkg::*;
#(
    parameter int NUM_ALARMS = 2,
    parameter int ADDR_W     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [7:0]            now_sec,
    input  logic [7:0]            now_min,
    input  logic [7:0]            now_hour,
    input  logic [7:0]            now_wday,
    input  logic [7:0]            now_date,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    output logic [NUM_ALARMS-1:0] alarm_flags,
    output logic                  irq_n
);
    localparam int CTRL_ADDR = NUM_ALARMS * FIELDS_PER_ALARM;
    localparam int STAT_ADDR = CTRL_ADDR + 1;

    rtc_time_t                               now;
    logic [NUM_ALARMS-1:0][FIELDS_PER_ALARM-1:0][7:0] cfg_q;
    logic [NUM_ALARMS-1:0]                   en_q;
    logic [NUM_ALARMS-1:0]                   hit;
    logic                                    stat_wr;

    // Gather the time inputs into one record.
    always_comb begin
        now     = '{sec: now_sec, min: now_min, hour: now_hour,
                    wday: now_wday, date: now_date};
        stat_wr = wr_en && (wr_addr == ADDR_W'(STAT_ADDR));
    end

    // Alarm compare registers and interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            en_q  <= '0;
        end else if (wr_en) begin
            for (int a = 0; a < NUM_ALARMS; a++)
                for (int f = 0; f < FIELDS_PER_ALARM; f++)
                    if (wr_addr == ADDR_W'(a * FIELDS_PER_ALARM + f))
                        cfg_q[a][f] <= wr_data;
            if (wr_addr == ADDR_W'(CTRL_ADDR))
                en_q <= wr_data[NUM_ALARMS-1:0];
        end
    end

    for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alarm
        alarm_match u_match (
            .now   (now),
            .cfg   (cfg_q[g]),
            .match (hit[g])
        );
        alarm_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (tick & hit[g]),
            .clr_evt (stat_wr & ~wr_data[g]),
            .flag    (alarm_flags[g])
        );
    end

    // Shared active-low interrupt.
    always_comb irq_n = ~|(alarm_flags & en_q);

    assert_irq_quiet_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> irq_n);
    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flags == '0) |-> irq_n);
endmodule

// File: tb/alarm_irq_unit_bench.sv
module alarm_irq_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] CTRL = 4'd8;
    localparam logic [3:0] STAT = 4'd9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_wday = '0, now_date = '0;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] alarm_flags;
    logic irq_n;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_irq_unit u_alarm_irq_unit (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_wday(now_wday), .now_date(now_date),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .alarm_flags(alarm_flags), .irq_n(irq_n)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_alarm(input int i, input logic [7:0] s, m, h, dd);
        wr(4'(4*i+0), s); wr(4'(4*i+1), m); wr(4'(4*i+2), h); wr(4'(4*i+3), dd);
    endtask

    task automatic set_time(input logic [7:0] s, m, h, wd, dt);
        now_sec = s; now_min = m; now_hour = h; now_wday = wd; now_date = dt;
    endtask

    task automatic pulse_tick;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(32'(alarm_flags), 0, "R1 flags after reset");
        chk(32'(irq_n), 1, "R1 irq_n after reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R4/R9: seconds sweep, alarm0 on 30 s only, alarm1 never matches
        set_alarm(0, 8'h30, 8'h80, 8'h80, 8'h80);
        set_alarm(1, 8'h80, 8'h45, 8'h80, 8'h80);
        for (int s = 0; s < 60; s++) begin
            set_time(bcd(s), 8'h12, 8'h05, 8'h02, 8'h11);
            pulse_tick();
            chk(32'(alarm_flags[0]), (s == 30) ? 1 : 0, "R2 seconds sweep flag0");
            chk(32'(alarm_flags[1]), 0, "R9 flag1 untouched in sweep");
            wr(STAT, 8'h02);
            chk(32'(alarm_flags), 0, "R6 clear flag0 only");
        end

        // R3: matching time with no tick
        set_time(8'h30, 8'h12, 8'h05, 8'h02, 8'h11);
        repeat (5) @(negedge clk);
        chk(32'(alarm_flags), 0, "R3 no set without tick");

        // R6: write 1 keeps flag, and cannot set a clear flag
        pulse_tick();
        chk(32'(alarm_flags), 1, "R2 flag0 set");
        wr(STAT, 8'hFF);
        chk(32'(alarm_flags), 1, "R6 write one keeps flags");
        wr(STAT, 8'h00);
        chk(32'(alarm_flags), 0, "R6 write zero clears");

        // R7: match and clear in the same cycle
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = STAT; wr_data = 8'h00;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        chk(32'(alarm_flags[0]), 1, "R7 match beats clear");
        wr(STAT, 8'h00);

        // R4: hour sweep with seconds and minutes compared exactly
        set_alarm(0, 8'h00, 8'h00, 8'h07, 8'h80);
        for (int h = 0; h < 24; h++) begin
            set_time(8'h00, 8'h00, bcd(h), 8'h01, 8'h01);
            pulse_tick();
            chk(32'(alarm_flags[0]), (h == 7) ? 1 : 0, "R4 hour sweep flag0");
            wr(STAT, 8'h00);
        end
        set_time(8'h00, 8'h01, 8'h07, 8'h01, 8'h01);
        pulse_tick();
        chk(32'(alarm_flags[0]), 0, "R4 unmasked minute mismatch");
        wr(STAT, 8'h00);

        // R5: weekday select then date select, same byte value 3
        set_alarm(1, 8'h80, 8'h80, 8'h80, 8'h43);
        for (int d = 1; d <= 7; d++) begin
            set_time(8'h10, 8'h20, 8'h08, 8'(d), 8'h03);
            pulse_tick();
            chk(32'(alarm_flags[1]), (d == 3) ? 1 : 0, "R5 weekday select flag1");
            wr(STAT, 8'h00);
        end
        wr(4'd7, 8'h03);
        for (int d = 1; d <= 31; d++) begin
            set_time(8'h10, 8'h20, 8'h08, 8'h03, bcd(d));
            pulse_tick();
            chk(32'(alarm_flags[1]), (d == 3) ? 1 : 0, "R5 date select flag1");
            wr(STAT, 8'h00);
        end

        // R8/R9: all flag and enable combinations
        set_alarm(0, 8'h80, 8'h80, 8'h80, 8'h80);
        set_alarm(1, 8'h80, 8'h80, 8'h80, 8'h80);
        for (int fl = 0; fl < 4; fl++) begin
            for (int en = 0; en < 4; en++) begin
                wr(CTRL, 8'(en));
                wr(STAT, 8'h00);
                pulse_tick();
                wr(STAT, 8'(fl));
                chk(32'(alarm_flags), 32'(fl), "R9 selective clear");
                chk(32'(irq_n), ((fl & en) != 0) ? 0 : 1, "R8 irq_n combination");
            end
        end

        // R1: reset after activity
        rst_n = 1'b0;
        @(negedge clk);
        chk(32'(alarm_flags), 0, "R1 flags after second reset");
        chk(32'(irq_n), 1, "R1 irq_n after second reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule